// File: doc/BRIEF.md
# Windowed Address Decoder Register File

This block routes the address of each transaction to a target identifier. It holds eight decode windows and one global register. Each window has a control word, a security word, a low page and a high page. When an enabled window covers an address, the transaction goes to that window's target. When no window covers it, the transaction goes to the default target held in the global register. Each window can also refuse non-secure writes, non-secure reads, or both. A refused access raises a violation flag and goes to the default target.

Software programs the windows through a simple 32-bit register port. Writes complete in one cycle and reads return data the same cycle. The lookup port is registered, so a lookup presented at one clock edge gives its result after that edge. Window 0 comes out of reset already decoding the internal configuration region, so lookups into that region work before any software runs.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, window 0 is enabled with target 0x0F and pages 0xF0000 to 0xF001F (addresses 0xF0_0000_0000 to 0xF0_01FF_FFFF). Windows 1 to 7 are disabled. The global default target is 0x00.
- R2: Register word address w*4+k selects window w. k=0 is control: bit 0 is enable and bits [11:4] are the target. k=1 is security: bit 0 is write-secure and bit 1 is read-secure. k=2 is the low page and k=3 is the high page, each holding address bits [39:20] in register bits [23:4]. Word address 32 is global, with the default target in bits [15:8]. Every other bit reads as 0, and any other address reads as 0.
- R3: A window matches when the address page (bits [39:20]) lies between the low page and the high page, both ends included. The first address past the window is (high register + 0x10) << 16.
- R4: A disabled window never matches.
- R5: When several enabled windows match, the lowest-numbered one supplies the target.
- R6: With no match, the output target is the global default target and hit is 0.
- R7: A non-secure write to a write-secure window, or a non-secure read from a read-secure window, gives violation 1, hit 0 and the default target. Secure accesses never cause a violation. Writing 0x1 to a security word sets write-secure and clears read-secure.
- R8: Lookup results and lk_valid_o appear one cycle after the lookup is presented.
- R9: A register write takes effect at the next clock edge, so a lookup in the following cycle sees the new value.
- R10: Address bits [19:0] do not affect the decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_addr_i | input | 40 | Transaction address |
| lk_write_i | input | 1 | 1 = write, 0 = read |
| lk_secure_i | input | 1 | 1 = secure access |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_target_o | output | 8 | Routed target ID |
| lk_hit_o | output | 1 | A window matched and allowed the access |
| lk_viol_o | output | 1 | Security violation |

## Verification
Directed lookups probe the page just below the low end, the low end, the high end, and the page just above the high end. These show whether the range check includes both ends. The same address is looked up again after its window is disabled, and again with two windows overlapping; this tells enable handling apart from priority order. All four combinations of secure and write are applied to windows marked write-secure and read-secure, which checks each violation condition separately. Random lookups then go into densely overlapping random windows, with random low-order address bits, and each result is compared against a reference model.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int unsigned PAGE_SHIFT  = 20;
  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_TID_LSB = 4;
  localparam int unsigned SEC_WS_BIT  = 0;
  localparam int unsigned SEC_RS_BIT  = 1;
  localparam int unsigned PAGE_LSB    = 4;
  localparam int unsigned GLB_TID_LSB = 8;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_SEC  = 2'd1,
    FLD_LO   = 2'd2,
    FLD_HI   = 2'd3
  } win_fld_e;
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned PAGE_W  = 20,
  parameter int unsigned TID_W   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 6,
  parameter logic [TID_W-1:0]  CFG_TID     = 8'h0F,
  parameter logic [PAGE_W-1:0] CFG_PAGE_LO = 20'hF0000,
  parameter logic [PAGE_W-1:0] CFG_PAGE_HI = 20'hF001F
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [REG_AW-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_WIN-1:0]                en_o,
  output logic [NUM_WIN-1:0][TID_W-1:0]     tid_o,
  output logic [NUM_WIN-1:0]                ws_o,
  output logic [NUM_WIN-1:0]                rs_o,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]    lo_o,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]    hi_o,
  output logic [TID_W-1:0]                  gtid_o
);
  localparam int unsigned WIN_IW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int unsigned WIN_SPAN = NUM_WIN * 4;
  localparam logic [REG_AW-1:0] GLB_ADDR = REG_AW'(WIN_SPAN);

  logic               in_win;
  logic [WIN_IW-1:0]  sel;
  win_fld_e           fld;

  assign in_win = (addr_i < GLB_ADDR);
  assign sel    = addr_i[2 +: WIN_IW];
  assign fld    = win_fld_e'(addr_i[1:0]);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam bit IS_CFG = (w == 0);
    logic wr_hit;
    assign wr_hit = we_i && in_win && (sel == WIN_IW'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[w]  <= IS_CFG;
        tid_o[w] <= IS_CFG ? CFG_TID : '0;
        ws_o[w]  <= 1'b0;
        rs_o[w]  <= 1'b0;
        lo_o[w]  <= IS_CFG ? CFG_PAGE_LO : '0;
        hi_o[w]  <= IS_CFG ? CFG_PAGE_HI : '0;
      end else if (wr_hit) begin
        unique case (fld)
          FLD_CTRL: begin
            en_o[w]  <= wdata_i[CTRL_EN_BIT];
            tid_o[w] <= wdata_i[CTRL_TID_LSB +: TID_W];
          end
          FLD_SEC: begin
            ws_o[w] <= wdata_i[SEC_WS_BIT];
            rs_o[w] <= wdata_i[SEC_RS_BIT];
          end
          FLD_LO: lo_o[w] <= wdata_i[PAGE_LSB +: PAGE_W];
          FLD_HI: hi_o[w] <= wdata_i[PAGE_LSB +: PAGE_W];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           gtid_o <= '0;
    else if (we_i && addr_i == GLB_ADDR)   gtid_o <= wdata_i[GLB_TID_LSB +: TID_W];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == GLB_ADDR) begin
      rdata_o[GLB_TID_LSB +: TID_W] = gtid_o;
    end else if (in_win) begin
      unique case (fld)
        FLD_CTRL: begin
          rdata_o[CTRL_EN_BIT]           = en_o[sel];
          rdata_o[CTRL_TID_LSB +: TID_W] = tid_o[sel];
        end
        FLD_SEC: begin
          rdata_o[SEC_WS_BIT] = ws_o[sel];
          rdata_o[SEC_RS_BIT] = rs_o[sel];
        end
        FLD_LO:  rdata_o[PAGE_LSB +: PAGE_W] = lo_o[sel];
        FLD_HI:  rdata_o[PAGE_LSB +: PAGE_W] = hi_o[sel];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/win_match.sv
module win_match #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned PAGE_W  = 20
) (
  input  logic [PAGE_W-1:0]              page_i,
  input  logic [NUM_WIN-1:0]             en_i,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0] lo_i,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0] hi_i,
  output logic [NUM_WIN-1:0]             match_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign match_o[w] = en_i[w] && (page_i >= lo_i[w]) && (page_i <= hi_i[w]);
  end
endmodule

// File: rtl/win_arbiter.sv
module win_arbiter #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned TID_W   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WIN-1:0]            match_i,
  input  logic [NUM_WIN-1:0][TID_W-1:0] tid_i,
  input  logic [NUM_WIN-1:0]            ws_i,
  input  logic [NUM_WIN-1:0]            rs_i,
  input  logic [TID_W-1:0]              gtid_i,
  input  logic                          valid_i,
  input  logic                          write_i,
  input  logic                          secure_i,
  output logic                          valid_o,
  output logic [TID_W-1:0]              target_o,
  output logic                          hit_o,
  output logic                          viol_o
);
  localparam int unsigned WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [WIN_IW-1:0] sel;
  logic              any, viol_d, hit_d;
  logic [TID_W-1:0]  tgt_d;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) sel = WIN_IW'(i);
    end
  end

  assign any    = |match_i;
  assign viol_d = any && !secure_i && (write_i ? ws_i[sel] : rs_i[sel]);
  assign hit_d  = any && !viol_d;
  assign tgt_d  = hit_d ? tid_i[sel] : gtid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      target_o <= '0;
      hit_o    <= 1'b0;
      viol_o   <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      target_o <= tgt_d;
      hit_o    <= hit_d;
      viol_o   <= viol_d;
    end
  end

  // R3
  hit_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(any));

  // R6
  miss_uses_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> target_o == $past(gtid_i));

  // R7
  viol_clears_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> !hit_o);

  // R7
  secure_never_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> !$past(secure_i));
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned TID_W   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = $clog2(NUM_WIN * 4 + 1),
  parameter logic [TID_W-1:0]           CFG_TID     = 8'h0F,
  parameter logic [ADDR_W-PAGE_SHIFT-1:0] CFG_PAGE_LO = 20'hF0000,
  parameter logic [ADDR_W-PAGE_SHIFT-1:0] CFG_PAGE_HI = 20'hF001F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_write_i,
  input  logic              lk_secure_i,
  output logic              lk_valid_o,
  output logic [TID_W-1:0]  lk_target_o,
  output logic              lk_hit_o,
  output logic              lk_viol_o
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [NUM_WIN-1:0]             en, ws, rs, match;
  logic [NUM_WIN-1:0][TID_W-1:0]  tid;
  logic [NUM_WIN-1:0][PAGE_W-1:0] lo, hi;
  logic [TID_W-1:0]               gtid;

  win_regfile #(
    .NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W), .TID_W(TID_W), .DATA_W(DATA_W),
    .REG_AW(REG_AW), .CFG_TID(CFG_TID), .CFG_PAGE_LO(CFG_PAGE_LO),
    .CFG_PAGE_HI(CFG_PAGE_HI)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .en_o(en), .tid_o(tid),
    .ws_o(ws), .rs_o(rs), .lo_o(lo), .hi_o(hi), .gtid_o(gtid)
  );

  win_match #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_match (
    .page_i(lk_addr_i[ADDR_W-1:PAGE_SHIFT]), .en_i(en), .lo_i(lo),
    .hi_i(hi), .match_o(match)
  );

  win_arbiter #(.NUM_WIN(NUM_WIN), .TID_W(TID_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match), .tid_i(tid),
    .ws_i(ws), .rs_i(rs), .gtid_i(gtid), .valid_i(lk_valid_i),
    .write_i(lk_write_i), .secure_i(lk_secure_i), .valid_o(lk_valid_o),
    .target_o(lk_target_o), .hit_o(lk_hit_o), .viol_o(lk_viol_o)
  );
endmodule

// File: tb/addr_win_decoder_tb.sv
module addr_win_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        lk_valid_i = 1'b0;
  logic [39:0] lk_addr_i = '0;
  logic        lk_write_i = 1'b0;
  logic        lk_secure_i = 1'b0;
  logic        lk_valid_o;
  logic [7:0]  lk_target_o;
  logic        lk_hit_o;
  logic        lk_viol_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  addr_win_decoder u_dut (.*);

  // reference model
  logic        m_en [8];
  logic [7:0]  m_tid[8];
  logic        m_ws [8];
  logic        m_rs [8];
  logic [19:0] m_lo [8];
  logic [19:0] m_hi [8];
  logic [7:0]  m_gtid;

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin
      m_en[i] = (i == 0); m_tid[i] = (i == 0) ? 8'h0F : 8'h00;
      m_ws[i] = 0; m_rs[i] = 0;
      m_lo[i] = (i == 0) ? 20'hF0000 : 20'h0;
      m_hi[i] = (i == 0) ? 20'hF001F : 20'h0;
    end
    m_gtid = 8'h00;
  endtask

  task automatic m_write(input logic [5:0] a, input logic [31:0] d);
    if (a == 6'd32) m_gtid = d[15:8];
    else if (a < 6'd32) begin
      case (a[1:0])
        2'd0: begin m_en[a[4:2]] = d[0]; m_tid[a[4:2]] = d[11:4]; end
        2'd1: begin m_ws[a[4:2]] = d[0]; m_rs[a[4:2]] = d[1]; end
        2'd2: m_lo[a[4:2]] = d[23:4];
        default: m_hi[a[4:2]] = d[23:4];
      endcase
    end
  endtask

  function automatic logic [31:0] m_read(input logic [5:0] a);
    logic [31:0] r = '0;
    if (a == 6'd32) r[15:8] = m_gtid;
    else if (a < 6'd32) begin
      case (a[1:0])
        2'd0: begin r[0] = m_en[a[4:2]]; r[11:4] = m_tid[a[4:2]]; end
        2'd1: begin r[0] = m_ws[a[4:2]]; r[1] = m_rs[a[4:2]]; end
        2'd2: r[23:4] = m_lo[a[4:2]];
        default: r[23:4] = m_hi[a[4:2]];
      endcase
    end
    return r;
  endfunction

  // returns {viol, hit, target}
  function automatic logic [9:0] m_lookup(input logic [39:0] a, input logic wr, input logic sc);
    logic [19:0] pg = a[39:20];
    bit found = 0;
    int idx = 0;
    logic v;
    for (int i = 0; i < 8; i++)
      if (!found && m_en[i] && pg >= m_lo[i] && pg <= m_hi[i]) begin found = 1; idx = i; end
    if (!found) return {1'b0, 1'b0, m_gtid};
    v = !sc && (wr ? m_ws[idx] : m_rs[idx]);
    if (v) return {1'b1, 1'b0, m_gtid};
    return {1'b0, 1'b1, m_tid[idx]};
  endfunction

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; lk_valid_i = 0;
    @(posedge clk_i);
    m_write(a, d);
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 check(req, 40'(reg_rdata_o), 40'(m_read(a)));
  endtask

  task automatic lk_chk(input string req, input logic [39:0] a, input logic wr, input logic sc);
    logic [9:0] e;
    @(negedge clk_i);
    lk_valid_i = 1; lk_addr_i = a; lk_write_i = wr; lk_secure_i = sc;
    e = m_lookup(a, wr, sc);
    @(posedge clk_i);
    #1;
    check(req, 40'({lk_valid_o, lk_viol_o, lk_hit_o, lk_target_o}), 40'({1'b1, e}));
  endtask

  task automatic set_win(input int w, input logic en, input logic [7:0] t,
                         input logic [19:0] lo, input logic [19:0] hi, input logic [1:0] sec);
    wr_reg(6'(w*4+1), {30'b0, sec});
    wr_reg(6'(w*4+2), {8'b0, lo, 4'b0});
    wr_reg(6'(w*4+3), {8'b0, hi, 4'b0});
    wr_reg(6'(w*4+0), {20'b0, t, 3'b0, en});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    check("R1 ctrl0", 40'(0), 40'(0));
    rd_chk("R1 ctrl0 read", 6'd0);
    check("R1 ctrl0 value", 40'(reg_rdata_o), 40'h0F1);
    rd_chk("R1 lo0", 6'd2);
    check("R1 lo0 value", 40'(reg_rdata_o), 40'h00F00000);
    rd_chk("R1 hi0", 6'd3);
    rd_chk("R1 ctrl1", 6'd4);
    rd_chk("R1 glb", 6'd32);
    lk_chk("R1 cfg hit", 40'hF0_0010_0000, 0, 1);
    check("R1 cfg target", 40'(lk_target_o), 40'h0F);
    lk_chk("R1 miss", 40'h00_0000_0000, 1, 0);

    // R2 field layout, unused bits read zero
    wr_reg(6'd4, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl mask", 6'd4);
    check("R2 ctrl value", 40'(reg_rdata_o), 40'h0FF1);
    wr_reg(6'd6, 32'hFFFF_FFFF);
    rd_chk("R2 lo mask", 6'd6);
    check("R2 lo value", 40'(reg_rdata_o), 40'h00FFFFF0);
    wr_reg(6'd5, 32'hFFFF_FFFF);
    rd_chk("R2 sec mask", 6'd5);
    wr_reg(6'd5, 32'h1);
    rd_chk("R7 write-secure clears read-secure", 6'd5);
    check("R7 sec value", 40'(reg_rdata_o), 40'h1);
    wr_reg(6'd32, 32'hFFFF_FFFF);
    rd_chk("R2 glb mask", 6'd32);
    rd_chk("R2 unmapped", 6'd40);
    wr_reg(6'd4, 32'h0);
    wr_reg(6'd32, 32'h0000_5A00);

    // R3 inclusive bounds, R9 write visible next cycle
    set_win(2, 1, 8'h22, 20'h00100, 20'h001FF, 2'b00);
    lk_chk("R3 R9 low end", 40'h00_1000_0000, 0, 0);
    lk_chk("R3 high end", 40'h00_1FFF_FFFF, 0, 0);
    lk_chk("R3 below", 40'h00_0FFF_FFFF, 0, 0);
    lk_chk("R3 one past", 40'h00_2000_0000, 0, 0);
    check("R6 default target", 40'(lk_target_o), 40'h5A);
    // R10 low bits ignored
    lk_chk("R10 offset", 40'h00_1AB1_2345, 1, 1);
    lk_chk("R10 offset2", 40'h00_1ABF_FFFF, 0, 1);

    // R4 disable
    wr_reg(6'd8, {20'b0, 8'h22, 4'b0000});
    lk_chk("R4 disabled", 40'h00_1000_0000, 0, 0);
    check("R4 hit", 40'(lk_hit_o), 40'h0);

    // R5 priority
    set_win(5, 1, 8'h55, 20'h00300, 20'h003FF, 2'b00);
    set_win(3, 1, 8'h33, 20'h00380, 20'h00480, 2'b00);
    lk_chk("R5 overlap", 40'h00_3900_0000, 0, 0);
    check("R5 lowest", 40'(lk_target_o), 40'h33);
    lk_chk("R5 only 5", 40'h00_3000_0000, 0, 0);

    // R7 security
    set_win(4, 1, 8'h44, 20'h00800, 20'h0080F, 2'b01);
    lk_chk("R7 ns write viol", 40'h00_8050_0000, 1, 0);
    check("R7 viol", 40'(lk_viol_o), 40'h1);
    lk_chk("R7 s write ok", 40'h00_8050_0000, 1, 1);
    lk_chk("R7 ns read ok", 40'h00_8050_0000, 0, 0);
    wr_reg(6'd17, 32'h2);
    lk_chk("R7 ns read viol", 40'h00_8050_0000, 0, 0);
    lk_chk("R7 s read ok", 40'h00_8050_0000, 0, 1);

    // R8 latency
    @(negedge clk_i); lk_valid_i = 0;
    @(posedge clk_i); #1 check("R8 valid low", 40'(lk_valid_o), 40'h0);

    // random
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 4) == 0) begin
        int w = 1 + ($urandom % 7);
        logic [19:0] lo = 20'($urandom % 48);
        set_win(w, 1'($urandom % 4 != 0), 8'($urandom), lo, lo + 20'($urandom % 16),
                2'($urandom));
        if (($urandom % 8) == 0) wr_reg(6'd32, $urandom);
      end
      lk_chk("R5 R7 R10 random", {20'($urandom % 64), 20'($urandom)},
             1'($urandom), 1'($urandom));
    end
    for (int a = 0; a < 33; a++) rd_chk("R2 readback sweep", 6'(a));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule